// File: doc/BRIEF.md
# Wormhole Output Connection Crossbar

This block sits between the switch allocator and the output buffers of a five-port wormhole router. It keeps a small connection record for each output port: which input owns the output, which virtual channel that input won, and whether a packet is in flight. When the allocator grants an input to an output, the record is written on the next clock edge. From then on the head, body and tail flits of that packet pass through without new arbitration. A flit moves in any cycle where the recorded input presents a valid flit on the recorded channel and the output buffer has room.

The input is selected by a registered one-hot vector. Each input flit bus is masked by its select bit and the masked buses are OR-reduced, so no index has to be decoded. The forward decision and the selected flit go straight to the write port of the output buffer. That buffer's write register is the only pipeline boundary on this path. In the same cycle, the block returns an acknowledge to the owning input buffer so that it pops the flit that was just written. When a flit marked as last is forwarded, the record is cleared and the output becomes free for the allocator again.

Top module: `wormhole_xbar`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output reads not busy, every write strobe and acknowledge is low, and every output flit bus is zero, whatever the inputs present.
- R2: A grant bit `gnt_flat[i*NPORTS+j]` installs input i on output j at the following clock edge. `out_busy[j]` rises in the next cycle, not in the grant cycle, and nothing is written to output j in the grant cycle.
- R3: `out_wr[j]` is high only when all four conditions hold: output j holds a connection, the owning input's `in_valid` is high, its presented channel `in_vc` equals the channel recorded at grant time (`gnt_vc` of that input), and `out_ready[j]` is high.
- R4: While output j holds a connection, `out_flit[j]` equals the flit bus of exactly the owning input.
- R5: `in_ack[i]` is high in exactly those cycles in which some output that input i owns has its write strobe high.
- R6: Flits after the head pass without a further grant. A cycle with a low valid, a low ready or a channel mismatch stalls the flow without losing the connection, and the flow resumes afterwards.
- R7: A flit whose bit FLIT_W-1 is 1 (last flit; kinds in bits [FLIT_W-1:FLIT_W-2]: 00 body, 01 head, 10 tail, 11 single-flit) releases the output when forwarded. `out_busy[j]` falls at the next edge, and later flits from the former owner are not written.
- R8: A grant that arrives in the same cycle as a tail flit is forwarded on that output takes priority. The output stays busy and the new input owns it from the next cycle.
- R9: An output without a connection drives `out_flit` to zero and `out_wr` low.
- R10: The source select of each output never has more than one bit set, provided the allocator grants each output to at most one input per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_flat | input | NPORTS*NPORTS | Allocator grants; bit i*NPORTS+j gives output j to input i |
| gnt_vc | input | NPORTS*VC_W | Channel each input requested, latched with its grant |
| in_flit | input | NPORTS*FLIT_W | Head flit of each input buffer |
| in_valid | input | NPORTS | Input buffer not empty |
| in_vc | input | NPORTS*VC_W | Channel each input currently presents |
| in_ack | output | NPORTS | Pop strobe to each input buffer |
| out_ready | input | NPORTS | Output buffer not full |
| out_wr | output | NPORTS | Write strobe to each output buffer |
| out_flit | output | NPORTS*FLIT_W | Write data to each output buffer |
| out_busy | output | NPORTS | Output owned by a packet; mask for the allocator |

## Verification
A corrupted source select shows up in the same cycle as a wrong or OR-merged `out_flit` word. Every input drives a distinct word, so the merge is visible. A wrong recorded channel shows up as a stalled output: `out_wr` and `in_ack` stay low while the owner is valid. A release that comes too early or too late shows up one cycle after the tail flit, either as a lost body flit or as a stale `out_busy` that blocks the next grant. The vector table walks grant, stall, channel mismatch, tail release and same-cycle regrant, and checks all four output groups every cycle.

// File: rtl/wx_pkg.sv
package wx_pkg;

  // Kind field in the two top bits of a flit.
  typedef enum logic [1:0] {
    KIND_BODY = 2'b00,
    KIND_HEAD = 2'b01,
    KIND_TAIL = 2'b10,
    KIND_SOLO = 2'b11
  } flit_kind_e;

  // A flit ends its packet when the top kind bit is set.
  function automatic logic kind_ends_packet(input flit_kind_e k);
    return (k == KIND_TAIL) || (k == KIND_SOLO);
  endfunction

endpackage

// File: rtl/wx_andor_sel.sv
// One-hot AND-OR selector: every lane is masked by its select bit and
// the lanes are OR-reduced. An all-zero select yields zero.
module wx_andor_sel #(
  parameter int unsigned LANES = 5,
  parameter int unsigned WIDTH = 16
) (
  input  logic [LANES-1:0]       sel,
  input  logic [LANES*WIDTH-1:0] lanes,
  output logic [WIDTH-1:0]       y
);

  always_comb begin
    y = '0;
    for (int unsigned i = 0; i < LANES; i++) begin
      y |= lanes[i*WIDTH +: WIDTH] & {WIDTH{sel[i]}};
    end
  end

endmodule

// File: rtl/wx_out_slice.sv
// Connection record, forward decision and data select for one output.
module wx_out_slice
  import wx_pkg::*;
#(
  parameter int unsigned NPORTS = 5,
  parameter int unsigned FLIT_W = 16,
  parameter int unsigned VC_W   = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        gnt_col,
  input  logic [NPORTS*VC_W-1:0]   gnt_vc,
  input  logic [NPORTS*FLIT_W-1:0] in_flit,
  input  logic [NPORTS-1:0]        in_valid,
  input  logic [NPORTS*VC_W-1:0]   in_vc,
  input  logic                     ready,
  output logic                     fwd,
  output logic [FLIT_W-1:0]        flit_o,
  output logic [NPORTS-1:0]        sel_o,
  output logic                     busy_o
);

  logic [NPORTS-1:0] sel_q;
  logic [VC_W-1:0]   vc_q;
  logic              live_q;
  logic              busy_q;

  logic [FLIT_W-1:0] pick_flit;
  logic [VC_W-1:0]   pick_vc;
  logic [VC_W-1:0]   grant_vc;
  logic              pick_valid;
  logic              grant_any;
  logic              last_fwd;

  wx_andor_sel #(.LANES(NPORTS), .WIDTH(FLIT_W)) u_flit_sel (
    .sel(sel_q), .lanes(in_flit), .y(pick_flit));

  wx_andor_sel #(.LANES(NPORTS), .WIDTH(VC_W)) u_vc_sel (
    .sel(sel_q), .lanes(in_vc), .y(pick_vc));

  wx_andor_sel #(.LANES(NPORTS), .WIDTH(1)) u_valid_sel (
    .sel(sel_q), .lanes(in_valid), .y(pick_valid));

  wx_andor_sel #(.LANES(NPORTS), .WIDTH(VC_W)) u_gvc_sel (
    .sel(gnt_col), .lanes(gnt_vc), .y(grant_vc));

  assign grant_any = |gnt_col;
  assign fwd       = live_q & pick_valid & (pick_vc == vc_q) & ready;
  assign last_fwd  = fwd & kind_ends_packet(flit_kind_e'(pick_flit[FLIT_W-1 -: 2]));

  // A new grant wins over a release in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      vc_q   <= '0;
      live_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (grant_any) begin
      sel_q  <= gnt_col;
      vc_q   <= grant_vc;
      live_q <= 1'b1;
      busy_q <= 1'b1;
    end else if (last_fwd) begin
      sel_q  <= '0;
      live_q <= 1'b0;
      busy_q <= 1'b0;
    end
  end

  assign flit_o = pick_flit;
  assign sel_o  = sel_q;
  assign busy_o = busy_q;

  p_install_r2: assert property (@(posedge clk) disable iff (rst)
    grant_any |=> busy_q && (sel_q == $past(gnt_col)));

  p_onehot_sel_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (last_fwd && !grant_any) |=> !busy_q && (sel_q == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_fwd && !grant_any) |=> busy_q && $stable(sel_q));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (flit_o == '0) && !fwd);

endmodule

// File: rtl/wormhole_xbar.sv
// Per-output wormhole connection state and one-hot crossbar for a
// router with NPORTS ports.
module wormhole_xbar #(
  parameter int unsigned NPORTS = 5,
  parameter int unsigned FLIT_W = 16,
  parameter int unsigned VC_W   = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPORTS*NPORTS-1:0]    gnt_flat,
  input  logic [NPORTS*VC_W-1:0]      gnt_vc,
  input  logic [NPORTS*FLIT_W-1:0]    in_flit,
  input  logic [NPORTS-1:0]           in_valid,
  input  logic [NPORTS*VC_W-1:0]      in_vc,
  output logic [NPORTS-1:0]           in_ack,
  input  logic [NPORTS-1:0]           out_ready,
  output logic [NPORTS-1:0]           out_wr,
  output logic [NPORTS*FLIT_W-1:0]    out_flit,
  output logic [NPORTS-1:0]           out_busy
);

  logic [NPORTS-1:0] sel_m [NPORTS];

  for (genvar j = 0; j < NPORTS; j++) begin : g_out
    logic [NPORTS-1:0] col;
    for (genvar i = 0; i < NPORTS; i++) begin : g_col
      assign col[i] = gnt_flat[i*NPORTS + j];
    end

    wx_out_slice #(.NPORTS(NPORTS), .FLIT_W(FLIT_W), .VC_W(VC_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .gnt_col  (col),
      .gnt_vc   (gnt_vc),
      .in_flit  (in_flit),
      .in_valid (in_valid),
      .in_vc    (in_vc),
      .ready    (out_ready[j]),
      .fwd      (out_wr[j]),
      .flit_o   (out_flit[j*FLIT_W +: FLIT_W]),
      .sel_o    (sel_m[j]),
      .busy_o   (out_busy[j])
    );

    p_wr_gated_r3: assert property (@(posedge clk) disable iff (rst)
      out_wr[j] |-> out_ready[j] && out_busy[j]);
  end

  // Pop the owning input in the same cycle its flit is written.
  always_comb begin
    in_ack = '0;
    for (int unsigned j = 0; j < NPORTS; j++) begin
      for (int unsigned i = 0; i < NPORTS; i++) begin
        in_ack[i] |= out_wr[j] & sel_m[j][i];
      end
    end
  end

  p_ack_pairs_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(in_ack) <= $countones(out_wr));

  p_ack_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (in_ack & ~in_valid) == '0);

endmodule

// File: tb/wormhole_xbar_bench.sv
module wormhole_xbar_bench;

  localparam int unsigned N  = 5;
  localparam int unsigned FW = 16;
  localparam int unsigned VW = 1;
  localparam int unsigned NROWS = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*N-1:0]  gnt_flat = '0;
  logic [N*VW-1:0] gnt_vc = '0;
  logic [N*FW-1:0] in_flit = '0;
  logic [N-1:0]    in_valid = '0;
  logic [N*VW-1:0] in_vc = '0;
  logic [N-1:0]    in_ack;
  logic [N-1:0]    out_ready = '1;
  logic [N-1:0]    out_wr;
  logic [N*FW-1:0] out_flit;
  logic [N-1:0]    out_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wormhole_xbar #(.NPORTS(N), .FLIT_W(FW), .VC_W(VW)) u_wormhole_xbar (
    .clk(clk), .rst(rst), .gnt_flat(gnt_flat), .gnt_vc(gnt_vc),
    .in_flit(in_flit), .in_valid(in_valid), .in_vc(in_vc), .in_ack(in_ack),
    .out_ready(out_ready), .out_wr(out_wr), .out_flit(out_flit),
    .out_busy(out_busy));

  // Row: {gnt 25, gvc 5, valid 5, vc 5, ready 5, last 5,
  //       exp_wr 5, exp_ack 5, exp_busy 5, exp_src 15 (3 per output, 7 = none)}
  localparam logic [79:0] TBL [NROWS] = '{
    {25'h0,      5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 15'h7FFF}, // idle, R9
    {25'h2,      5'b00000, 5'b00001, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 15'h7FFF}, // grant 0->1, R2
    {25'h0,      5'b00000, 5'b00001, 5'b00000, 5'b11111, 5'b00000, 5'b00010, 5'b00001, 5'b00010, 15'h7FC7}, // head moves, R3 R5
    {25'h0,      5'b00000, 5'b00001, 5'b00000, 5'b11101, 5'b00000, 5'b00000, 5'b00000, 5'b00010, 15'h7FC7}, // not ready, R6
    {25'h0,      5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00010, 15'h7FC7}, // not valid, R6
    {25'h0,      5'b00000, 5'b00001, 5'b00001, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00010, 15'h7FC7}, // vc mismatch, R3
    {25'h0,      5'b00000, 5'b00001, 5'b00000, 5'b11111, 5'b00001, 5'b00010, 5'b00001, 5'b00010, 15'h7FC7}, // tail, R7
    {25'h0,      5'b00000, 5'b00001, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 15'h7FFF}, // released, R7
    {25'h102000, 5'b00100, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 15'h7FFF}, // 2->3 vc1, 4->0
    {25'h0,      5'b00000, 5'b10100, 5'b00100, 5'b11111, 5'b00000, 5'b01001, 5'b10100, 5'b01001, 15'h75FC}, // parallel, R4
    {25'h100,    5'b00000, 5'b10100, 5'b00100, 5'b11111, 5'b00100, 5'b01001, 5'b10100, 5'b01001, 15'h75FC}, // tail + grant 1->3, R8
    {25'h0,      5'b00000, 5'b10110, 5'b00100, 5'b11111, 5'b10000, 5'b01001, 5'b10010, 5'b01001, 15'h73FC}, // new owner, R8
    {25'h0,      5'b00000, 5'b10010, 5'b00000, 5'b11111, 5'b00010, 5'b01000, 5'b00010, 5'b01000, 15'h73FF}, // out0 freed, R7
    {25'h0,      5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 15'h7FFF}  // all idle, R9
  };

  function automatic logic [FW-1:0] mk_flit(input logic last, input int step, input int port);
    return {last, 3'b000, 8'(step), 4'(port)};
  endfunction

  task automatic chk(input string req, input string what, input int row,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s row %0d actual %h expected %h", req, what, row, act, exp);
    end
  endtask

  task automatic drive_flits(input logic [N-1:0] last, input int step);
    for (int i = 0; i < N; i++) in_flit[i*FW +: FW] = mk_flit(last[i], step, i);
  endtask

  initial begin
    // R1: reset state while inputs are busy
    drive_flits('0, 200);
    in_valid = '1;
    repeat (2) @(posedge clk);
    @(negedge clk); #5;
    chk("R1", "busy", -1, 80'(out_busy), 80'(0));
    chk("R1", "wr",   -1, 80'(out_wr),   80'(0));
    chk("R1", "ack",  -1, 80'(in_ack),   80'(0));
    chk("R1", "flit", -1, 80'(out_flit), 80'(0));
    @(negedge clk);
    rst = 1'b0;
    in_valid = '0;

    for (int r = 0; r < NROWS; r++) begin
      logic [79:0] v;
      v = TBL[r];
      @(negedge clk);
      gnt_flat  = v[79:55];
      gnt_vc    = v[54:50];
      in_valid  = v[49:45];
      in_vc     = v[44:40];
      out_ready = v[39:35];
      drive_flits(v[34:30], r);
      #5;
      chk("R3", "out_wr",   r, 80'(out_wr),   80'(v[29:25]));
      chk("R5", "in_ack",   r, 80'(in_ack),   80'(v[24:20]));
      chk("R2", "out_busy", r, 80'(out_busy), 80'(v[19:15]));
      for (int j = 0; j < N; j++) begin
        int src;
        logic [FW-1:0] ef;
        src = int'(v[j*3 +: 3]);
        ef  = (src == 7) ? '0 : mk_flit(v[30 + src], r, src);
        // R4, R10: distinct words per input expose a merged select
        chk("R4", $sformatf("out_flit[%0d]", j), r,
            80'(out_flit[j*FW +: FW]), 80'(ef));
      end
    end

    // R1: reset during a live connection drops it
    @(negedge clk);
    gnt_flat = 25'h20000;  // input 3 to output 2
    gnt_vc = '0; in_valid = '0; in_vc = '0; out_ready = '1;
    drive_flits('0, 90);
    @(negedge clk);
    gnt_flat = '0;
    in_valid = 5'b01000;
    #5;
    chk("R3", "wr before reset", 100, 80'(out_wr), 80'(5'b00100));
    chk("R5", "ack before reset", 100, 80'(in_ack), 80'(5'b01000));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #5;
    chk("R1", "busy after reset", 101, 80'(out_busy), 80'(0));
    chk("R1", "wr after reset",   101, 80'(out_wr),   80'(0));
    chk("R9", "flit after reset", 101, 80'(out_flit), 80'(0));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #5;
    chk("R9", "idle wr", 102, 80'(out_wr), 80'(0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule